// File: doc/BRIEF.md
# Operand-Snooping Reservation Station

This block holds instructions that have been issued to one functional unit but cannot start yet. Each issued instruction carries an operation code, a destination tag and two source operands. An operand either arrives as a finished 32-bit value or as a nonzero producer tag that names the unit that will compute it. The instruction is written into a free slot and waits there.

A shared result broadcast bus delivers each finished result together with its producer tag. Every busy slot compares the waiting tag of each of its operands against the broadcast tag. On a match, the slot stores the value in place and clears the tag. No register file is read.

Once both operands of a slot hold values, the slot offers itself for dispatch. When the functional unit signals that it can accept work, the lowest-numbered offering slot is handed over and freed on the same clock edge. Instructions arrive in program order over a valid/ready issue port. Dispatch uses a valid/ready pair toward the unit.

Top module: `rs_station`

## Requirements
- R1: After reset every slot is empty, so `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An instruction issued with both operand tags equal to 0 is offered on the dispatch port from the cycle after the issue edge. Its operation, destination and both operand values appear unchanged.
- R3: An operand with a nonzero tag blocks dispatch until a broadcast carries that same tag. A broadcast with any other tag leaves the slot untouched. An operand whose tag is 0 is never overwritten by a broadcast.
- R4: A broadcast with `bc_valid` 1 and a matching tag replaces the operand with `bc_val` and clears its tag. Every waiting operand in every slot with that tag does this on the same edge, and the slot can be dispatched in the following cycle.
- R5: An operand that is issued in the same cycle as a broadcast with its tag captures the broadcast value at issue.
- R6: While `fu_ready` is 0, an offered slot stays offered with its contents unchanged, and `dsp_valid` stays 1.
- R7: When several slots are dispatchable, the lowest-index one is offered, and `dsp_slot` reports that index.
- R8: A slot is freed on the edge where `dsp_valid` and `fu_ready` are both 1. It can accept a new instruction from the next cycle on.
- R9: When every slot is busy, `iss_ready` is 0, and an instruction presented with `iss_valid` 1 is discarded and never dispatched.
- R10: A new instruction is written into the lowest-index free slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one slot free |
| iss_op | input | 4 | Operation code of the issued instruction |
| iss_dst | input | 3 | Destination tag of the issued instruction |
| iss_a_tag | input | 3 | Producer tag of operand A, 0 when the value is present |
| iss_a_val | input | 32 | Value of operand A |
| iss_b_tag | input | 3 | Producer tag of operand B, 0 when the value is present |
| iss_b_val | input | 32 | Value of operand B |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 3 | Producer tag of the broadcast result |
| bc_val | input | 32 | Broadcast result value |
| dsp_valid | output | 1 | A slot with both operands present is offered |
| fu_ready | input | 1 | Functional unit accepts the offered instruction |
| dsp_slot | output | 2 | Index of the offered slot |
| dsp_op | output | 4 | Operation code of the offered instruction |
| dsp_dst | output | 3 | Destination tag of the offered instruction |
| dsp_a | output | 32 | Operand A value of the offered instruction |
| dsp_b | output | 32 | Operand B value of the offered instruction |

## Verification
Two things can happen on one edge: an issue and a result broadcast with the tag that the issued operand waits for. If the issue path ignored the bus, the slot would wait forever. The bench drives the broadcast in the same cycle as the issue, with the matching tag on operand A in one vector and on operand B in another. It then checks that the slot is dispatchable immediately and carries the broadcast value. A second overlap is a dispatch that frees a slot while the next issue waits. This is judged by the index the refilled slot reports.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DATA_W = 32;
  localparam int RS_TAG_W  = 3;
  localparam int RS_OP_W   = 4;

  typedef logic [RS_DATA_W-1:0] data_t;
  typedef logic [RS_TAG_W-1:0]  tag_t;
  typedef logic [RS_OP_W-1:0]   op_t;

  // tag == 0: value present; otherwise waiting on that producer
  typedef struct packed {
    tag_t  tag;
    data_t val;
  } opnd_t;

  // Apply a broadcast to one operand.
  function automatic opnd_t snoop(opnd_t cur, logic bv, tag_t bt, data_t bd);
    opnd_t res;
    res = cur;
    if (bv && (cur.tag != '0) && (cur.tag == bt)) begin
      res.tag = '0;
      res.val = bd;
    end
    return res;
  endfunction
endpackage

// File: rtl/rs_prio.sv
module rs_prio #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_en,
  input  op_t   in_op,
  input  tag_t  in_dst,
  input  opnd_t in_a,
  input  opnd_t in_b,
  input  logic  bc_valid,
  input  tag_t  bc_tag,
  input  data_t bc_val,
  input  logic  free_en,
  output logic  busy,
  output logic  rdy,
  output op_t   out_op,
  output tag_t  out_dst,
  output data_t out_a,
  output data_t out_b
);
  logic  busy_q, busy_d;
  op_t   op_q, op_d;
  tag_t  dst_q, dst_d;
  opnd_t a_q, a_d, b_q, b_d;
  logic  pay_en;

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    dst_d  = dst_q;
    a_d    = snoop(a_q, bc_valid, bc_tag, bc_val);
    b_d    = snoop(b_q, bc_valid, bc_tag, bc_val);
    if (free_en) busy_d = 1'b0;
    if (alloc_en) begin
      busy_d = 1'b1;
      op_d   = in_op;
      dst_d  = in_dst;
      a_d    = snoop(in_a, bc_valid, bc_tag, bc_val);
      b_d    = snoop(in_b, bc_valid, bc_tag, bc_val);
    end
  end

  assign pay_en = alloc_en | (busy_q & bc_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      op_q  <= op_d;
      dst_q <= dst_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign busy    = busy_q;
  assign rdy     = busy_q && (a_q.tag == '0) && (b_q.tag == '0);
  assign out_op  = op_q;
  assign out_dst = dst_q;
  assign out_a   = a_q.val;
  assign out_b   = b_q.val;

  // R8
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !busy_q);
  // R6
  free_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> rdy);
  // R6
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !free_en) |=> (rdy && $stable(a_q.val) && $stable(b_q.val) && $stable(op_q)));
  // R4
  wake_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !free_en && bc_valid && (a_q.tag != '0) && (a_q.tag == bc_tag))
      |=> ((a_q.tag == '0) && (a_q.val == $past(bc_val))));
  // R3
  wait_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !free_en && (b_q.tag != '0) && !(bc_valid && (bc_tag == b_q.tag)))
      |=> $stable(b_q));
  // R5
  issue_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && bc_valid && (in_a.tag != '0) && (in_a.tag == bc_tag))
      |=> ((a_q.tag == '0) && (a_q.val == $past(bc_val))));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  output logic                 iss_ready,
  input  logic [RS_OP_W-1:0]   iss_op,
  input  logic [RS_TAG_W-1:0]  iss_dst,
  input  logic [RS_TAG_W-1:0]  iss_a_tag,
  input  logic [RS_DATA_W-1:0] iss_a_val,
  input  logic [RS_TAG_W-1:0]  iss_b_tag,
  input  logic [RS_DATA_W-1:0] iss_b_val,
  input  logic                 bc_valid,
  input  logic [RS_TAG_W-1:0]  bc_tag,
  input  logic [RS_DATA_W-1:0] bc_val,
  output logic                 dsp_valid,
  input  logic                 fu_ready,
  output logic [SLOT_W-1:0]    dsp_slot,
  output logic [RS_OP_W-1:0]   dsp_op,
  output logic [RS_TAG_W-1:0]  dsp_dst,
  output logic [RS_DATA_W-1:0] dsp_a,
  output logic [RS_DATA_W-1:0] dsp_b
);
  logic [NUM_SLOTS-1:0] busy_vec, rdy_vec, free_vec;
  logic [NUM_SLOTS-1:0] alloc_gnt, dsp_gnt;
  logic [NUM_SLOTS-1:0] alloc_en, free_en;
  logic [SLOT_W-1:0]    alloc_idx;
  logic                 any_free;
  op_t                  op_arr  [NUM_SLOTS];
  tag_t                 dst_arr [NUM_SLOTS];
  data_t                a_arr   [NUM_SLOTS];
  data_t                b_arr   [NUM_SLOTS];
  opnd_t                in_a, in_b;

  assign in_a     = '{tag: iss_a_tag, val: iss_a_val};
  assign in_b     = '{tag: iss_b_tag, val: iss_b_val};
  assign free_vec = ~busy_vec;

  rs_prio #(.N(NUM_SLOTS)) u_alloc_pick (
    .req(free_vec), .grant(alloc_gnt), .idx(alloc_idx), .any(any_free)
  );

  rs_prio #(.N(NUM_SLOTS)) u_dsp_pick (
    .req(rdy_vec), .grant(dsp_gnt), .idx(dsp_slot), .any(dsp_valid)
  );

  assign iss_ready = any_free;
  assign alloc_en  = alloc_gnt & {NUM_SLOTS{iss_valid}};
  assign free_en   = dsp_gnt & {NUM_SLOTS{fu_ready}};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rs_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_en (alloc_en[g]),
      .in_op    (iss_op),
      .in_dst   (iss_dst),
      .in_a     (in_a),
      .in_b     (in_b),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .free_en  (free_en[g]),
      .busy     (busy_vec[g]),
      .rdy      (rdy_vec[g]),
      .out_op   (op_arr[g]),
      .out_dst  (dst_arr[g]),
      .out_a    (a_arr[g]),
      .out_b    (b_arr[g])
    );
  end

  assign dsp_op  = op_arr[dsp_slot];
  assign dsp_dst = dst_arr[dsp_slot];
  assign dsp_a   = a_arr[dsp_slot];
  assign dsp_b   = b_arr[dsp_slot];

  // R9
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (&busy_vec));
  // R7
  lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (rdy_vec[dsp_slot] &&
      ((rdy_vec & ~({NUM_SLOTS{1'b1}} << dsp_slot)) == '0)));
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dsp_gnt) && $onehot0(alloc_gnt));
  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !fu_ready) |=> dsp_valid);
  // R2
  ready_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && (iss_a_tag == '0) && (iss_b_tag == '0)) |=> dsp_valid);
  // R10
  lowest_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> (free_vec[alloc_idx] &&
      ((free_vec & ~({NUM_SLOTS{1'b1}} << alloc_idx)) == '0)));
endmodule

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_ready;
  logic [3:0]  iss_op;
  logic [2:0]  iss_dst, iss_a_tag, iss_b_tag;
  logic [31:0] iss_a_val, iss_b_val;
  logic        bc_valid;
  logic [2:0]  bc_tag;
  logic [31:0] bc_val;
  logic        dsp_valid, fu_ready;
  logic [1:0]  dsp_slot;
  logic [3:0]  dsp_op;
  logic [2:0]  dsp_dst;
  logic [31:0] dsp_a, dsp_b;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  rs_station dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_val(bc_val), .dsp_valid(dsp_valid), .fu_ready(fu_ready), .dsp_slot(dsp_slot),
    .dsp_op(dsp_op), .dsp_dst(dsp_dst), .dsp_a(dsp_a), .dsp_b(dsp_b)
  );

  typedef struct packed {
    logic [2:0]  at;
    logic [31:0] av;
    logic [2:0]  bt;
    logic [31:0] bv;
    logic        same;
    logic [2:0]  ct;
    logic [31:0] cv;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'd11, 3'd0, 32'd22, 1'b0, 3'd0, 32'd0,   32'd11,  32'd22},
    '{3'd3, 32'd0,  3'd0, 32'd5,  1'b0, 3'd3, 32'd100, 32'd100, 32'd5},
    '{3'd0, 32'd7,  3'd4, 32'd0,  1'b0, 3'd4, 32'd200, 32'd7,   32'd200},
    '{3'd2, 32'd0,  3'd2, 32'd0,  1'b0, 3'd2, 32'd300, 32'd300, 32'd300},
    '{3'd5, 32'd0,  3'd0, 32'd9,  1'b1, 3'd5, 32'd400, 32'd400, 32'd9},
    '{3'd0, 32'd1,  3'd6, 32'd0,  1'b1, 3'd6, 32'd77,  32'd1,   32'd77},
    '{3'd0, 32'd42, 3'd0, 32'd43, 1'b1, 3'd1, 32'd999, 32'd42,  32'd43}
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_issue(input logic [3:0] op, input logic [2:0] dst,
                             input logic [2:0] at, input logic [31:0] av,
                             input logic [2:0] bt, input logic [31:0] bv);
    iss_valid = 1'b1;
    iss_op    = op;
    iss_dst   = dst;
    iss_a_tag = at;
    iss_a_val = av;
    iss_b_tag = bt;
    iss_b_val = bv;
  endtask

  task automatic broadcast(input logic [2:0] t, input logic [31:0] v);
    bc_valid = 1'b1;
    bc_tag   = t;
    bc_val   = v;
    tick();
    bc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; bc_valid = 1'b0; fu_ready = 1'b0;
    iss_op = '0; iss_dst = '0; iss_a_tag = '0; iss_a_val = '0;
    iss_b_tag = '0; iss_b_val = '0; bc_tag = '0; bc_val = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R1 iss_ready", 32'(iss_ready), 32'd1);
    chk("R1 dsp_valid", 32'(dsp_valid), 32'd0);

    // Vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      drive_issue(4'(i + 1), 3'(i), VECS[i].at, VECS[i].av, VECS[i].bt, VECS[i].bv);
      if (VECS[i].same) begin
        bc_valid = 1'b1; bc_tag = VECS[i].ct; bc_val = VECS[i].cv;
      end
      tick();
      iss_valid = 1'b0;
      bc_valid  = 1'b0;
      if (!VECS[i].same && VECS[i].ct != 3'd0) begin
        chk("R3 waiting blocks", 32'(dsp_valid), 32'd0);
        broadcast(VECS[i].ct ^ 3'd1, 32'hdead);
        chk("R3 other tag ignored", 32'(dsp_valid), 32'd0);
        broadcast(VECS[i].ct, VECS[i].cv);
      end
      chk("R2 R4 R5 dsp_valid", 32'(dsp_valid), 32'd1);
      chk("R2 R4 R5 dsp_a", dsp_a, VECS[i].ea);
      chk("R2 R4 R5 dsp_b", dsp_b, VECS[i].eb);
      chk("R2 dsp_op", 32'(dsp_op), 32'(i + 1));
      chk("R2 dsp_dst", 32'(dsp_dst), 32'(i));
      tick();
      chk("R6 held valid", 32'(dsp_valid), 32'd1);
      chk("R6 held a", dsp_a, VECS[i].ea);
      fu_ready = 1'b1;
      tick();
      fu_ready = 1'b0;
      chk("R8 drained", 32'(dsp_valid), 32'd0);
    end

    // R7, R8, R10: priority and refill
    drive_issue(4'd1, 3'd1, 3'd5, 32'd0, 3'd0, 32'd10); tick();
    drive_issue(4'd2, 3'd2, 3'd0, 32'd2, 3'd0, 32'd20); tick();
    drive_issue(4'd3, 3'd3, 3'd0, 32'd3, 3'd0, 32'd30); tick();
    drive_issue(4'd4, 3'd4, 3'd0, 32'd4, 3'd0, 32'd40); tick();
    iss_valid = 1'b0;
    chk("R9 full", 32'(iss_ready), 32'd0);
    chk("R7 lowest ready slot", 32'(dsp_slot), 32'd1);
    chk("R7 lowest ready dst", 32'(dsp_dst), 32'd2);
    fu_ready = 1'b1;
    tick();
    fu_ready = 1'b0;
    chk("R7 next slot", 32'(dsp_slot), 32'd2);
    chk("R8 slot freed", 32'(iss_ready), 32'd1);
    drive_issue(4'd6, 3'd6, 3'd0, 32'd6, 3'd0, 32'd60); tick();
    iss_valid = 1'b0;
    chk("R10 refill lowest", 32'(dsp_slot), 32'd1);
    chk("R10 refill dst", 32'(dsp_dst), 32'd6);
    broadcast(3'd5, 32'd50);
    fu_ready = 1'b1;
    begin
      logic [2:0] order [4] = '{3'd1, 3'd6, 3'd3, 3'd4};
      for (int k = 0; k < 4; k++) begin
        chk("R7 drain slot", 32'(dsp_slot), 32'(k));
        chk("R7 drain dst", 32'(dsp_dst), 32'(order[k]));
        tick();
      end
    end
    fu_ready = 1'b0;
    chk("R8 empty", 32'(dsp_valid), 32'd0);

    // R9, R4: full station refuses; one broadcast wakes every slot
    for (int k = 0; k < 4; k++) begin
      drive_issue(4'd9, 3'(k), 3'd7, 32'd0, 3'd0, 32'(k + 100));
      tick();
    end
    iss_valid = 1'b0;
    chk("R9 ready low", 32'(iss_ready), 32'd0);
    drive_issue(4'd15, 3'd7, 3'd0, 32'd1, 3'd0, 32'd2);
    tick();
    iss_valid = 1'b0;
    chk("R9 refused not stored", 32'(dsp_valid), 32'd0);
    broadcast(3'd7, 32'h55);
    fu_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R4 wake slot", 32'(dsp_slot), 32'(k));
      chk("R4 wake a", dsp_a, 32'h55);
      chk("R4 wake b", dsp_b, 32'(k + 100));
      tick();
    end
    fu_ready = 1'b0;
    chk("R9 refused never dispatched", 32'(dsp_valid), 32'd0);
    chk("R8 all free", 32'(iss_ready), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule